// File: doc/BRIEF.md
# Dual-Supply Output Sequencing Controller

This block decides what the open-drain outputs of an isolated dual-supply window comparator show while its two supplies come up, go down, or fail. It has three output modes. In the high-impedance mode every pull-low enable is released. In the forced-low mode every output is pulled low, which tells the system that the high side is not working. In the run mode each output follows its own comparator result from the high side.

Two synchronous supply-good flags select the mode: one for the low side and one for the high side. Four parameterised cycle timers also take part. The low-side start-up timer runs while the low-side flag is valid. The high-side start-up-plus-blanking timer runs while the high-side flag is valid. The fault timer measures how long the high side has been unusable once the low side is ready. A high-side fault must last the full qualification delay before the outputs are forced low. After any high-side drop-out, run mode comes back only when the complete start-up and blanking window has passed again.

Top module: `supply_seq_ctrl`

## Requirements
- R1: While the low-side flag is valid and the run and forced-low conditions have not yet been met, every pull-low enable is 0 and the status reads 0 (high-impedance).
- R2: With the low-side flag valid and the high-side flag not yet usable, the status becomes 1 and every pull-low enable becomes 1 on the (LS_START + HS_FAULT + 1)-th rising edge that samples the low-side flag valid.
- R3: In run mode, if the high-side flag is sampled invalid on HS_FAULT consecutive edges, the status becomes 1 on the next edge and every enable is 1.
- R4: Run mode (status 2) is entered only after the high-side flag has been sampled valid on HS_START + HS_BLANK consecutive edges, and the low-side start-up has completed. It is entered on the edge after both conditions hold.
- R5: If the high side is already fully started when the low-side flag rises, the status goes from 0 to 2 on the (LS_START + 1)-th edge that samples the low-side flag valid.
- R6: If the high side comes up shortly after the low side, the status first becomes 1 when the fault delay expires. It becomes 2 once the high-side start-up and blanking window completes.
- R7: In the same cycle that the low-side flag is 0, every pull-low enable is 0 and the status reads 0, whatever the high side is doing. The internal mode returns to high-impedance at the next edge.
- R8: In run mode, pull-low enable i equals comparator bit i, so an asserted result pulls its pin low.
- R9: In run mode, a high-side drop of fewer than HS_FAULT consecutive sampled cycles leaves the status and outputs unchanged, and the fault count restarts from zero when the flag returns.
- R10: After a high-side drop-out that forced the outputs low, the high-side start-up and blanking count restarts from zero. Run mode resumes only after HS_START + HS_BLANK further valid samples.
- R11: The 2-bit status uses the encodings 0 = high-impedance, 1 = forced low and 2 = run. The value 3 never appears.
- R12: A synchronous reset, applied while the low-side flag is 0, gives status 0, all enables 0 and all timers cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ls_good | input | 1 | Low-side supply valid flag |
| hs_good | input | 1 | High-side supply valid flag |
| cmp_res | input | NCH | Window comparator results from the high side, 1 = asserted |
| pull_low | output | NCH | Per-output pull-low enable, 0 = released (high-impedance) |
| mode_o | output | 2 | Current output mode: 0 high-impedance, 1 forced low, 2 run |

## Verification
A wrong timer or mode register shows at the ports as a status or enable change on the wrong edge. A fault qualified too early appears as a premature forced-low cycle, and a skipped restart of the blanking count appears as an early return to run mode. Both differ from the expected sequence within one clock of the edge where the correct timer would have expired. The bench therefore compares the status and both enables on every cycle against a behavioural model. It also pins down the exact edge of each transition in the power-up, drop-out and recovery orderings. A stuck low-side gating is caught in the same cycle that the low-side flag falls.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

  typedef enum logic [1:0] {
    MODE_HIZ = 2'd0,
    MODE_LOW = 2'd1,
    MODE_RUN = 2'd2
  } out_mode_e;

  // counter width able to hold 0..lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // mode transition rule shared by the mode register
  function automatic out_mode_e next_mode(
    input out_mode_e cur,
    input logic      ls_ok,
    input logic      ls_rdy,
    input logic      hs_rdy,
    input logic      flt
  );
    out_mode_e nxt;
    nxt = cur;
    if (!ls_ok) begin
      nxt = MODE_HIZ;
    end else if (cur == MODE_RUN) begin
      nxt = flt ? MODE_LOW : MODE_RUN;
    end else if (ls_rdy && hs_rdy) begin
      nxt = MODE_RUN;
    end else if (flt) begin
      nxt = MODE_LOW;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/seqc_sat_timer.sv
module seqc_sat_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic done
);
  import seqc_pkg::*;

  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIM);

endmodule

// File: rtl/seqc_mode_fsm.sv
module seqc_mode_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       ls_good,
  input  logic       hs_good,
  input  logic       ls_ready,
  input  logic       hs_ready,
  input  logic       flt_done,
  output logic [1:0] mode_q,
  output logic       hs_usable
);
  import seqc_pkg::*;

  out_mode_e state_q;
  out_mode_e state_d;

  // in run mode the link is up, so only the raw flag counts;
  // otherwise the high side must complete start-up and blanking
  assign hs_usable = (state_q == MODE_RUN) ? hs_good : hs_ready;

  always_comb begin
    state_d = next_mode(state_q, ls_good, ls_ready, hs_ready, flt_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MODE_HIZ;
    end else begin
      state_q <= state_d;
    end
  end

  assign mode_q = state_q;

endmodule

// File: rtl/seqc_out_stage.sv
module seqc_out_stage #(
  parameter int unsigned NCH = 2
) (
  input  logic           ls_good,
  input  logic [1:0]     mode_q,
  input  logic [NCH-1:0] cmp_res,
  output logic [NCH-1:0] pull_low,
  output logic [1:0]     mode_o
);
  import seqc_pkg::*;

  logic force_low;
  logic follow;

  assign force_low = ls_good && (mode_q == MODE_LOW);
  assign follow    = ls_good && (mode_q == MODE_RUN);
  assign mode_o    = ls_good ? mode_q : MODE_HIZ;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign pull_low[i] = force_low || (follow && cmp_res[i]);
  end

endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned LS_START = 8,
  parameter int unsigned HS_START = 6,
  parameter int unsigned HS_BLANK = 10,
  parameter int unsigned HS_FAULT = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ls_good,
  input  logic           hs_good,
  input  logic [NCH-1:0] cmp_res,
  output logic [NCH-1:0] pull_low,
  output logic [1:0]     mode_o
);

  localparam int unsigned HS_WIN = HS_START + HS_BLANK;

  logic       ls_ready;
  logic       hs_ready;
  logic       flt_done;
  logic       hs_usable;
  logic       flt_run;
  logic       flt_clear;
  logic [1:0] mode_q;

  assign flt_run   = ls_ready && !hs_usable;
  assign flt_clear = !ls_good || hs_usable;

  seqc_sat_timer #(.LIMIT(LS_START)) u_ls_tmr (
    .clk(clk), .rst(rst), .run(ls_good), .clear(!ls_good), .done(ls_ready)
  );

  seqc_sat_timer #(.LIMIT(HS_WIN)) u_hs_tmr (
    .clk(clk), .rst(rst), .run(hs_good), .clear(!hs_good), .done(hs_ready)
  );

  seqc_sat_timer #(.LIMIT(HS_FAULT)) u_flt_tmr (
    .clk(clk), .rst(rst), .run(flt_run), .clear(flt_clear), .done(flt_done)
  );

  seqc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .ls_good(ls_good), .hs_good(hs_good),
    .ls_ready(ls_ready), .hs_ready(hs_ready), .flt_done(flt_done),
    .mode_q(mode_q), .hs_usable(hs_usable)
  );

  seqc_out_stage #(.NCH(NCH)) u_out (
    .ls_good(ls_good), .mode_q(mode_q), .cmp_res(cmp_res),
    .pull_low(pull_low), .mode_o(mode_o)
  );

endmodule

// File: rtl/seqc_checker.sv
module seqc_checker #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           ls_good,
  input logic           hs_good,
  input logic [NCH-1:0] cmp_res,
  input logic [NCH-1:0] pull_low,
  input logic [1:0]     mode_q,
  input logic           ls_ready,
  input logic           hs_ready,
  input logic           flt_done
);

  AST_LS_LOSS_HIZ: assert property (@(posedge clk) disable iff (rst)
    !ls_good |=> (mode_q == 2'd0)); // R7

  AST_LS_LOSS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !ls_good |-> (pull_low == '0)); // R7

  AST_RUN_ENTRY_READY: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd2 && $past(mode_q) != 2'd2) |-> $past(ls_ready && hs_ready)); // R4

  AST_LOW_ENTRY_FAULT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1 && $past(mode_q) != 2'd1) |-> $past(flt_done)); // R3

  AST_HIZ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0) |-> (pull_low == '0)); // R1

  AST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (ls_good && mode_q == 2'd2) |-> (pull_low == cmp_res)); // R8

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ls_good && mode_q == 2'd2 && hs_good) |=> !flt_done); // R9

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'd3); // R11

endmodule

bind supply_seq_ctrl seqc_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .ls_good(ls_good), .hs_good(hs_good),
  .cmp_res(cmp_res), .pull_low(pull_low), .mode_q(mode_q),
  .ls_ready(ls_ready), .hs_ready(hs_ready), .flt_done(flt_done)
);

// File: tb/test_supply_seq_ctrl.sv
`timescale 1ns/1ps
module test_supply_seq_ctrl;

  localparam int LS  = 8;
  localparam int HSS = 6;
  localparam int HSB = 10;
  localparam int FLT = 5;
  localparam int WIN = HSS + HSB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ls_good = 1'b0;
  logic       hs_good = 1'b0;
  logic [1:0] cmp_res = 2'b00;
  logic [1:0] pull_low;
  logic [1:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R12";

  // behavioural reference state
  int ls_t = 0, hs_t = 0, fl_t = 0, m_ref = 0;

  always #5 clk = ~clk;

  supply_seq_ctrl #(.NCH(2), .LS_START(LS), .HS_START(HSS), .HS_BLANK(HSB),
                    .HS_FAULT(FLT)) i_supply_seq_ctrl (
    .clk(clk), .rst(rst), .ls_good(ls_good), .hs_good(hs_good),
    .cmp_res(cmp_res), .pull_low(pull_low), .mode_o(mode_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_pull();
    if (!ls_good) return 0;
    if (m_ref == 1) return 3;
    if (m_ref == 2) return int'(cmp_res);
    return 0;
  endfunction

  // one clock: advance the model at the edge, compare in the low phase
  task automatic cyc();
    bit lsr, hsr, fd, usable;
    @(posedge clk);
    if (rst) begin
      ls_t = 0; hs_t = 0; fl_t = 0; m_ref = 0;
    end else begin
      lsr = (ls_t >= LS);
      hsr = (hs_t >= WIN);
      fd  = (fl_t >= FLT);
      usable = (m_ref == 2) ? hs_good : hsr;
      if (!ls_good) m_ref = 0;
      else if (m_ref == 2) m_ref = fd ? 1 : 2;
      else if (lsr && hsr) m_ref = 2;
      else if (fd) m_ref = 1;
      ls_t = ls_good ? ((ls_t < LS) ? ls_t + 1 : ls_t) : 0;
      hs_t = hs_good ? ((hs_t < WIN) ? hs_t + 1 : hs_t) : 0;
      if (!ls_good || usable) fl_t = 0;
      else if (lsr && fl_t < FLT) fl_t = fl_t + 1;
    end
    @(negedge clk);
    chk({tag, " R11 mode"}, int'(mode_o), ls_good ? m_ref : 0);
    chk({tag, " pull"}, int'(pull_low), exp_pull());
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12 reset with low side invalid
    run(3);
    chk("R12 reset mode", int'(mode_o), 0);
    chk("R12 reset pull", int'(pull_low), 0);
    rst = 1'b0;
    run(2);

    // R1/R2: low side alone, high side absent
    tag = "R1";
    ls_good = 1'b1; cmp_res = 2'b11;
    #1 chk("R1 hiz after ls rise", int'(pull_low), 0);
    run(LS + FLT);
    chk("R1 still hiz before fault", int'(mode_o), 0);
    tag = "R2";
    run(1);
    chk("R2 forced low on time", int'(mode_o), 1);
    chk("R2 both low", int'(pull_low), 3);
    run(5);

    // R4: high side arrives long after
    tag = "R4";
    hs_good = 1'b1;
    run(WIN);
    chk("R4 not run before window", int'(mode_o), 1);
    run(1);
    chk("R4 run after window", int'(mode_o), 2);

    // R8: comparator patterns in run mode
    tag = "R8";
    for (int p = 0; p < 4; p++) begin
      cmp_res = 2'(p);
      run(2);
      chk("R8 follow", int'(pull_low), p);
    end

    // R9: short high-side drop
    tag = "R9";
    cmp_res = 2'b01;
    hs_good = 1'b0;
    run(FLT - 1);
    hs_good = 1'b1;
    run(FLT + 3);
    chk("R9 short drop ignored", int'(mode_o), 2);
    hs_good = 1'b0;
    run(FLT - 1);
    hs_good = 1'b1;
    run(2);
    chk("R9 repeat drop ignored", int'(pull_low), 1);

    // R3: qualified drop in run mode
    tag = "R3";
    run(WIN + 2);
    hs_good = 1'b0;
    run(FLT);
    chk("R3 still run at delay", int'(mode_o), 2);
    run(1);
    chk("R3 forced low", int'(mode_o), 1);
    run(6);

    // R10: recovery restarts the full window
    tag = "R10";
    hs_good = 1'b1;
    run(WIN);
    chk("R10 still low", int'(mode_o), 1);
    run(1);
    chk("R10 run after full window", int'(mode_o), 2);
    cmp_res = 2'b10;
    run(3);

    // R7: low side lost while running
    tag = "R7";
    ls_good = 1'b0;
    #1;
    chk("R7 immediate mode", int'(mode_o), 0);
    chk("R7 immediate release", int'(pull_low), 0);
    run(4);

    // R5: high side already up when low side starts
    tag = "R5";
    ls_good = 1'b1;
    run(LS);
    chk("R5 hiz during ls start", int'(mode_o), 0);
    run(1);
    chk("R5 run after ls start", int'(mode_o), 2);
    run(3);

    // R6: high side shortly after low side
    tag = "R6";
    ls_good = 1'b0; hs_good = 1'b0;
    run(3);
    ls_good = 1'b1;
    run(3);
    hs_good = 1'b1;
    run(LS + FLT + 1 - 3);
    chk("R6 low at fault expiry", int'(mode_o), 1);
    run(WIN + 3 + 1 - (LS + FLT + 1));
    chk("R6 run after blanking", int'(mode_o), 2);
    run(3);

    // R12: reset again with low side down
    tag = "R12";
    ls_good = 1'b0; rst = 1'b1;
    run(2);
    rst = 1'b0;
    ls_good = 1'b1; hs_good = 1'b0;
    run(LS + FLT);
    chk("R12 timers cleared", int'(mode_o), 0);
    run(1);
    chk("R12 fault after fresh count", int'(mode_o), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule